// File: doc/BRIEF.md
# Five-Operation Word-Addressed Processor Core

This block is a small 32-bit processor core. It fetches one 32-bit instruction word per step from a word-addressed memory and runs it against a six-entry register set. The register set holds four data registers, the program counter and the instruction register. The instruction word is split into an 8-bit operation code, two 4-bit operand selectors and a 16-bit literal. A selector value of 0xF stands for that literal, zero-extended, in place of a register. The five operations are: stop, load from memory, store to memory, move, and add.

The memory port is a plain synchronous port with fixed timing. The core drives an address with a read or write strobe in one cycle, and read data returns on the following cycle. A bus decoder reports an access to an unmapped address through an error input in the same cycle as the strobe. The port has no back-pressure, so there is no valid/ready handshake: the memory must accept every strobe and must return read data exactly one cycle later. Whenever a fault occurs, or a stop instruction is reached, the core parks in a halted state that only reset clears. The `halted` output reports that state.

Top module: `cpu_core`

## Requirements
- R1: After reset, `halted` is low, R0 to R3 read as zero, and the first access is a read of word address 0x0100.
- R2: Each step reads the word at the program counter, places it in the instruction register and adds one to the program counter. Reads return data one cycle after the strobe, and the cycle after a read strobe carries no access. Move, add, store, stop and no-operation steps each take 3 cycles. A load step takes 4 cycles.
- R3: The instruction word is laid out as follows: bits 31:24 hold the opcode, bits 23:20 hold selector A, bits 19:16 hold selector B (which is also the destination), and bits 15:0 hold the literal. Selectors 0x0 to 0x3 name R0 to R3. Selector 0xD names the program counter, which reads as the address of the next word. Selector 0xE names the instruction register. Selector 0xF names the zero-extended literal.
- R4: Opcode 0x00 halts the core, whatever its other fields hold. Once halted, the core makes no further memory access until reset.
- R5: Opcode 0x01 reads the word at the address held by operand A into destination B.
- R6: Opcode 0x02 writes the value of operand A to the address held by operand B.
- R7: Opcode 0x03 copies operand A into destination B. When the destination is the program counter, execution continues at the copied address.
- R8: Opcode 0x04 writes the sum A + B, modulo 2^32, into destination B.
- R9: A destination selector of 0xF discards the result, and execution continues.
- R10: A selector value from 0x4 to 0xC in either field halts the core without changing any state. This applies to every opcode other than 0x00.
- R11: An asserted `mem_err` during a fetch, load or store halts the core. An operand address with nonzero bits above bit 15 also halts the core, and in that case no bus access is made.
- R12: Opcodes 0x05 to 0xFF with valid selectors change nothing, and execution continues at the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address of the current access |
| mem_re | output | 1 | Read strobe; data expected on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_re` |
| mem_err | input | 1 | Bus decoder flags the current address as unmapped |
| halted | output | 1 | Core is stopped until reset |

## Verification
A corrupted register or selector decode shows up at the ports as a wrong value in a later store, or as a `halted` rise in the wrong cycle. Because every step takes a fixed 3 or 4 cycles, a fault becomes visible within a few cycles of the instruction that caused it. The bench therefore runs short programs that dump the affected register to memory, and it checks both the stored word and the exact cycle on which the core halts. Sweeps cover every unused opcode, every reserved selector in both fields, and a range of sums that includes wrap-around, with every expected value computed arithmetically.

// File: rtl/cpu_core_pkg.sv
package cpu_core_pkg;
  localparam int OPC_W = 8;
  localparam int IDX_W = 4;
  localparam int IMM_W = 16;

  localparam logic [OPC_W-1:0] OPC_STOP  = 8'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 8'h01;
  localparam logic [OPC_W-1:0] OPC_STORE = 8'h02;
  localparam logic [OPC_W-1:0] OPC_MOVE  = 8'h03;
  localparam logic [OPC_W-1:0] OPC_SUM   = 8'h04;

  localparam logic [IDX_W-1:0] IDX_PC  = 4'hD;
  localparam logic [IDX_W-1:0] IDX_IR  = 4'hE;
  localparam logic [IDX_W-1:0] IDX_IMM = 4'hF;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_LATCH,
    ST_EXEC,
    ST_RDBACK,
    ST_STOP
  } core_state_t;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [IDX_W-1:0] sel_a;
    logic [IDX_W-1:0] sel_b;
    logic [IMM_W-1:0] imm;
  } instr_t;

  typedef struct packed {
    logic stop;
    logic load;
    logic store;
    logic move;
    logic sum;
  } op_class_t;
endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_GPR = 4,
  parameter logic [DATA_W-1:0] RESET_PC = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_step,
  input  logic              ir_load,
  input  logic [DATA_W-1:0] ir_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic [DATA_W-1:0] imm_val,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic [DATA_W-1:0] pc_q,
  output logic [DATA_W-1:0] ir_q
);
  logic [DATA_W-1:0] gpr_view [NUM_GPR];

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) q <= wr_data;
    end
    assign gpr_view[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else if (wr_en && wr_idx == IDX_PC) pc_q <= wr_data;
    else if (pc_step) pc_q <= pc_q + DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_q <= '0;
    else if (ir_load) ir_q <= ir_data;
    else if (wr_en && wr_idx == IDX_IR) ir_q <= wr_data;
  end

  function automatic logic [DATA_W-1:0] pick(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int k = 0; k < NUM_GPR; k++)
      if (idx == IDX_W'(k)) v = gpr_view[k];
    if (idx == IDX_PC) v = pc_q;
    if (idx == IDX_IR) v = ir_q;
    if (idx == IDX_IMM) v = imm_val;
    return v;
  endfunction

  always_comb begin
    rd_a = pick(rd_a_idx);
    rd_b = pick(rd_b_idx);
  end
endmodule

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_GPR = 4
) (
  input  logic [31:0]       instr,
  output op_class_t         cls,
  output logic [IDX_W-1:0]  sel_a,
  output logic [IDX_W-1:0]  sel_b,
  output logic [DATA_W-1:0] imm_ext,
  output logic              sel_ok,
  output logic              dest_live
);
  instr_t f;
  assign f = instr_t'(instr);

  function automatic logic idx_valid(input logic [IDX_W-1:0] i);
    return (int'(i) < NUM_GPR) || (i >= IDX_PC);
  endfunction

  always_comb begin
    cls       = '0;
    cls.stop  = (f.opc == OPC_STOP);
    cls.load  = (f.opc == OPC_LOAD);
    cls.store = (f.opc == OPC_STORE);
    cls.move  = (f.opc == OPC_MOVE);
    cls.sum   = (f.opc == OPC_SUM);
    sel_a     = f.sel_a;
    sel_b     = f.sel_b;
    imm_ext   = DATA_W'(f.imm);
    sel_ok    = idx_valid(f.sel_a) && idx_valid(f.sel_b);
    dest_live = (f.sel_b != IDX_IMM);
  end
endmodule

// File: rtl/cpu_exec.sv
module cpu_exec
  import cpu_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  op_class_t         cls,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              addr_ok
);
  logic [DATA_W-1:0] addr_src;

  always_comb begin
    result   = cls.sum ? (opnd_a + opnd_b) : opnd_a;
    addr_src = cls.load ? opnd_a : opnd_b;
    acc_addr = addr_src[ADDR_W-1:0];
    addr_ok  = ((addr_src >> ADDR_W) == '0);
  end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int NUM_GPR = 4,
  parameter logic [DATA_W-1:0] RESET_PC = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              halted
);
  core_state_t       st_q, st_d;
  logic              rf_wr_en, pc_step, ir_load;
  logic [DATA_W-1:0] rf_wr_data, opnd_a, opnd_b, pc_q, ir_q, imm_ext, result;
  logic [IDX_W-1:0]  sel_a, sel_b;
  logic              sel_ok, dest_live, addr_ok, pc_ok;
  logic [ADDR_W-1:0] acc_addr;
  op_class_t         cls;

  cpu_regfile #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR), .RESET_PC(RESET_PC)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rf_wr_en), .wr_idx(sel_b), .wr_data(rf_wr_data),
    .pc_step(pc_step), .ir_load(ir_load), .ir_data(mem_rdata),
    .rd_a_idx(sel_a), .rd_b_idx(sel_b), .imm_val(imm_ext),
    .rd_a(opnd_a), .rd_b(opnd_b), .pc_q(pc_q), .ir_q(ir_q)
  );

  cpu_decode #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_dec (
    .instr(ir_q[31:0]), .cls(cls), .sel_a(sel_a), .sel_b(sel_b),
    .imm_ext(imm_ext), .sel_ok(sel_ok), .dest_live(dest_live)
  );

  cpu_exec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_exe (
    .cls(cls), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .acc_addr(acc_addr), .addr_ok(addr_ok)
  );

  assign pc_ok     = ((pc_q >> ADDR_W) == '0);
  assign mem_wdata = opnd_a;
  assign halted    = (st_q == ST_STOP);

  always_comb begin
    st_d       = st_q;
    mem_re     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = pc_q[ADDR_W-1:0];
    rf_wr_en   = 1'b0;
    rf_wr_data = result;
    pc_step    = 1'b0;
    ir_load    = 1'b0;
    unique case (st_q)
      ST_FETCH: begin
        if (!pc_ok) st_d = ST_STOP;
        else begin
          mem_re = 1'b1;
          st_d   = mem_err ? ST_STOP : ST_LATCH;
        end
      end
      ST_LATCH: begin
        ir_load = 1'b1;
        pc_step = 1'b1;
        st_d    = ST_EXEC;
      end
      ST_EXEC: begin
        mem_addr = acc_addr;
        if (cls.stop || !sel_ok) st_d = ST_STOP;
        else if (cls.load || cls.store) begin
          if (!addr_ok) st_d = ST_STOP;
          else begin
            mem_re = cls.load;
            mem_we = cls.store;
            if (mem_err) st_d = ST_STOP;
            else st_d = cls.load ? ST_RDBACK : ST_FETCH;
          end
        end else begin
          rf_wr_en = (cls.move || cls.sum) && dest_live;
          st_d     = ST_FETCH;
        end
      end
      ST_RDBACK: begin
        rf_wr_en   = dest_live;
        rf_wr_data = mem_rdata;
        st_d       = ST_FETCH;
      end
      default: st_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FETCH;
    else st_q <= st_d;
  end
endmodule

// File: rtl/cpu_core_checker.sv
module cpu_core_checker (
  input logic clk,
  input logic rst_n,
  input logic mem_re,
  input logic mem_we,
  input logic mem_err,
  input logic halted
);
  p_single_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  p_read_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (!mem_re && !mem_we));

  p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_re && !mem_we));

  p_halt_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_err_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_re || mem_we) && mem_err) |=> halted);
endmodule

bind cpu_core cpu_core_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_re(mem_re), .mem_we(mem_we),
  .mem_err(mem_err), .halted(halted)
);

// File: tb/tb_cpu_core.sv
module tb_cpu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_re, mem_we, mem_err, halted;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int vectors = 0;
  int fails = 0;
  int quiet_viol = 0;
  int unsigned ld_ptr;
  logic [31:0] ram [int unsigned];
  logic        first_re, first_halt;
  logic [15:0] first_addr;

  always #5 clk = ~clk;

  cpu_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .halted(halted)
  );

  // bus decoder: words 0x0000..0xFFE0 mapped
  assign mem_err = (mem_re || mem_we) && (mem_addr > 16'hFFE0);

  always @(posedge clk) begin
    if (mem_we && !mem_err) ram[{16'h0, mem_addr}] = mem_wdata;
    if (mem_re) mem_rdata <= ram.exists({16'h0, mem_addr}) ? ram[{16'h0, mem_addr}] : 32'h0;
    if (rst_n && halted && (mem_re || mem_we)) quiet_viol++;
  end

  function automatic logic [31:0] enc(input logic [7:0] op, input logic [3:0] a,
                                      input logic [3:0] b, input logic [15:0] imm);
    return {op, a, b, imm};
  endfunction

  function automatic logic [31:0] peek(input int unsigned a);
    return ram.exists(a) ? ram[a] : 32'h0;
  endfunction

  task automatic clear();
    ram.delete();
    ld_ptr = 32'h100;
  endtask

  task automatic emit(input logic [31:0] w);
    ram[ld_ptr] = w;
    ld_ptr++;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go(output int cyc);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    first_re = mem_re;
    first_addr = mem_addr;
    first_halt = halted;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] a, b, w;

    // R1: reset state, registers dumped to preset words
    clear();
    for (int k = 0; k < 4; k++) emit(enc(8'h02, 4'(k), 4'hF, 16'(16'h2000 + k)));
    emit(32'h0);
    for (int k = 0; k < 4; k++) ram[32'h2000 + k] = 32'hDEAD;
    go(cyc);
    chk("R1 first read strobe", 32'(first_re), 32'h1);
    chk("R1 first address", 32'(first_addr), 32'h100);
    chk("R1 halted low", 32'(first_halt), 32'h0);
    for (int k = 0; k < 4; k++) chk("R1 gpr zero", peek(32'h2000 + k), 32'h0);
    chk("R2 cycles five stores", 32'(cyc), 32'd15);

    // R6 R7 R8: demo program, sum stored at 0x1000
    clear();
    emit(32'h03F00005); emit(32'h03F10010); emit(32'h03F21000);
    emit(32'h04010000); emit(32'h02120000); emit(32'h00000000);
    go(cyc);
    chk("R8 demo sum", peek(32'h1000), 32'h15);
    chk("R2 demo cycles", 32'(cyc), 32'd18);

    // R5 R8: add sweep through loads, including wrap
    for (int k = 0; k < 16; k++) begin
      a = 32'h9E3779B9 * k;
      b = 32'hFFFFFFFF - 32'h12345678 * k;
      if (k == 15) begin a = 32'hFFFFFFFF; b = 32'h1; end
      clear();
      ram[32'h3000] = a; ram[32'h3001] = b;
      emit(enc(8'h01, 4'hF, 4'h0, 16'h3000));
      emit(enc(8'h01, 4'hF, 4'h1, 16'h3001));
      emit(enc(8'h04, 4'h0, 4'h1, 16'h0));
      emit(enc(8'h02, 4'h1, 4'hF, 16'h3002));
      emit(32'h0);
      go(cyc);
      chk("R8 add wrap sweep", peek(32'h3002), a + b);
      chk("R5 R2 load timing", 32'(cyc), 32'd17);
    end

    // R8 R3: add with literal operand
    clear();
    emit(enc(8'h03, 4'hF, 4'h1, 16'h10));
    emit(32'h04F10003);
    emit(enc(8'h02, 4'h1, 4'hF, 16'h4010));
    emit(32'h0);
    go(cyc);
    chk("R8 add literal", peek(32'h4010), 32'h13);

    // R4: stop ignores fields, then no bus activity
    clear();
    emit(32'h00111111);
    emit(enc(8'h02, 4'hF, 4'hF, 16'h4011));
    go(cyc);
    chk("R4 stop cycle", 32'(cyc), 32'd3);
    chk("R4 no marker", peek(32'h4011), 32'h0);
    repeat (20) @(negedge clk);
    chk("R4 halt sticky", 32'(halted), 32'h1);
    chk("R4 quiet while halted", 32'(quiet_viol), 32'h0);

    // R3 R7: program counter and instruction register as sources
    clear();
    emit(enc(8'h03, 4'hD, 4'h2, 16'h0));
    emit(enc(8'h02, 4'h2, 4'hF, 16'h4003));
    emit(32'h0);
    go(cyc);
    chk("R3 pc reads next word", peek(32'h4003), 32'h101);
    clear();
    w = enc(8'h03, 4'hE, 4'h3, 16'hABCD);
    emit(w);
    emit(enc(8'h02, 4'h3, 4'hF, 16'h4004));
    emit(32'h0);
    go(cyc);
    chk("R3 ir source", peek(32'h4004), w);

    // R7: copy into program counter jumps
    clear();
    emit(enc(8'h03, 4'hF, 4'hD, 16'h0200));
    emit(enc(8'h02, 4'hF, 4'hF, 16'h4001));
    emit(32'h0);
    ram[32'h200] = enc(8'h02, 4'hF, 4'hF, 16'h4002);
    ram[32'h201] = 32'h0;
    go(cyc);
    chk("R7 jump skips word", peek(32'h4001), 32'h0);
    chk("R7 jump target runs", peek(32'h4002), 32'h4002);
    chk("R7 jump cycles", 32'(cyc), 32'd9);

    // R9: literal destination discards
    clear();
    ram[32'h4030] = 32'h5555;
    emit(enc(8'h03, 4'hF, 4'h0, 16'h1234));
    emit(enc(8'h04, 4'h0, 4'hF, 16'h0));
    emit(enc(8'h01, 4'hF, 4'hF, 16'h4030));
    emit(enc(8'h03, 4'hF, 4'hF, 16'h0007));
    emit(enc(8'h02, 4'h0, 4'hF, 16'h4005));
    emit(32'h0);
    go(cyc);
    chk("R9 discard keeps R0", peek(32'h4005), 32'h1234);
    chk("R9 discard cycles", 32'(cyc), 32'd19);

    // R10: reserved selectors in both fields
    for (int idx = 4; idx <= 12; idx++) begin
      for (int pos = 0; pos < 2; pos++) begin
        clear();
        emit(pos == 1 ? enc(8'h03, 4'h0, 4'(idx), 16'h0) : enc(8'h03, 4'(idx), 4'h0, 16'h0));
        emit(enc(8'h02, 4'hF, 4'hF, 16'h4040));
        emit(32'h0);
        go(cyc);
        chk("R10 reserved halts", 32'(cyc), 32'd3);
        chk("R10 no marker", peek(32'h4040), 32'h0);
      end
    end
    clear();
    emit(enc(8'h09, 4'h5, 4'h0, 16'h0));
    emit(enc(8'h02, 4'hF, 4'hF, 16'h4040));
    emit(32'h0);
    go(cyc);
    chk("R10 reserved with unused opcode", 32'(cyc), 32'd3);

    // R12: unused opcodes are no-ops
    for (int op = 5; op < 256; op++) begin
      clear();
      emit(enc(8'(op), 4'h0, 4'h1, 16'h4050));
      emit(enc(8'h02, 4'hF, 4'hF, 16'h4041));
      emit(32'h0);
      go(cyc);
      chk("R12 no-op continues", peek(32'h4041), 32'h4041);
      chk("R12 no-op cycles", 32'(cyc), 32'd9);
    end

    // R6 R5 R11: boundary and faults
    clear();
    emit(enc(8'h02, 4'hF, 4'hF, 16'hFFE0));
    emit(32'h0);
    go(cyc);
    chk("R6 store at top mapped word", peek(32'hFFE0), 32'hFFE0);
    chk("R6 store cycles", 32'(cyc), 32'd6);

    clear();
    ram[32'hFFE0] = 32'hCAFEBABE;
    emit(enc(8'h01, 4'hF, 4'h2, 16'hFFE0));
    emit(enc(8'h02, 4'h2, 4'hF, 16'h4020));
    emit(32'h0);
    go(cyc);
    chk("R5 load top mapped word", peek(32'h4020), 32'hCAFEBABE);
    chk("R5 load cycles", 32'(cyc), 32'd10);

    clear();
    emit(enc(8'h03, 4'hF, 4'h0, 16'h0099));
    emit(enc(8'h01, 4'hF, 4'h0, 16'hFFE1));
    emit(enc(8'h02, 4'hF, 4'hF, 16'h4060));
    emit(32'h0);
    go(cyc);
    chk("R11 load fault halts", 32'(cyc), 32'd6);
    chk("R11 load fault no marker", peek(32'h4060), 32'h0);

    clear();
    emit(enc(8'h02, 4'hF, 4'hF, 16'hFFE1));
    emit(enc(8'h02, 4'hF, 4'hF, 16'h4061));
    go(cyc);
    chk("R11 store fault halts", 32'(cyc), 32'd3);
    chk("R11 store fault no marker", peek(32'h4061), 32'h0);

    clear();
    emit(enc(8'h03, 4'hF, 4'h0, 16'hFFFF));
    emit(enc(8'h04, 4'hF, 4'h0, 16'h0001));
    emit(enc(8'h02, 4'hF, 4'h0, 16'h0005));
    emit(enc(8'h02, 4'hF, 4'hF, 16'h4062));
    emit(32'h0);
    go(cyc);
    chk("R11 wide address halts", 32'(cyc), 32'd9);
    chk("R11 wide address no access", peek(32'h0), 32'h0);
    chk("R11 wide address no marker", peek(32'h4062), 32'h0);

    clear();
    emit(enc(8'h03, 4'hF, 4'hD, 16'hFFE1));
    go(cyc);
    chk("R11 fetch fault halts", 32'(cyc), 32'd4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule